// File: doc/BRIEF.md
# Light-load burst mode controller

This block decides when a switching power controller drops into burst operation at light load and when it returns to normal valley switching. It watches digital flags from the feedback comparators, together with the valley target chosen by the normal-mode logic. Burst is entered only when three things hold at once: the feedback is low, the valley target is at its largest value, and both of these have stayed true for a blanking window.

While in burst, the block gates switching with hysteresis. Switching is enabled when the feedback rises past an upper flag and disabled when it falls past a lower flag. While switching is enabled, a fixed-period timer starts each pulse. A pulse ends at the burst current trip or at half the period, whichever comes first. A reduced current limit is selected for the whole burst.

When the feedback crosses an exit flag, the block leaves burst and restores the full current limit. It also pulses a request so that the valley counter restarts from its lowest value. Timer periods and the blanking time are parameters counted in clock cycles.

Top module: `lite_burst_ctrl`

## Requirements
- R1: After reset, burst_o=0, sw_en_o=1, gate_o=0, low_ilim_o=0 and valley_rst_o=0.
- R2: In normal mode, burst_o rises at the clock edge that samples the BLANK_CYC-th consecutive cycle with fb_low_i=1 and valley_tgt_i equal to 7 (3'b111).
- R3: If fb_low_i=0 or valley_tgt_i!=7 is sampled in any cycle of the blanking window, the window restarts from zero. Burst then needs BLANK_CYC further consecutive qualifying cycles.
- R4: In burst, sw_en_o goes to 1 one edge after fb_on_i=1 is sampled. It goes to 0 one edge after fb_off_i=1 is sampled while fb_on_i=0. It holds when neither flag is set. When burst is first entered, sw_en_o is 0.
- R5: While sw_en_o=1 in burst, the phase timer restarts at 0 when switching is enabled. A turn-on happens every PERIOD_CYC cycles. gate_o is high for at most PERIOD_CYC/2 consecutive cycles. gate_o is 0 outside burst and whenever sw_en_o=0 in burst.
- R6: Sampling cur_trip_i=1 while gate_o=1 ends the pulse at that edge. A trip sampled in the turn-on cycle (phase 0) is ignored.
- R7: low_ilim_o is 1 exactly while burst_o=1.
- R8: In burst, sampling fb_exit_i=1 clears burst_o at that edge. sw_en_o returns to 1, and gate_o to 0, in the same cycle.
- R9: valley_rst_o is high for exactly the one cycle in which burst_o has just fallen, and is 0 otherwise.
- R10: fb_exit_i, fb_on_i, fb_off_i and cur_trip_i have no effect in normal mode: the outputs stay burst_o=0, sw_en_o=1, gate_o=0, valley_rst_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_low_i | input | 1 | Feedback is below the burst entry level |
| valley_tgt_i | input | VT_W | Valley target from the normal-mode logic |
| fb_on_i | input | 1 | Feedback is above the burst switching-on level |
| fb_off_i | input | 1 | Feedback is below the burst switching-off level |
| fb_exit_i | input | 1 | Feedback is above the burst exit level |
| cur_trip_i | input | 1 | Burst current trip comparator |
| burst_o | output | 1 | Burst mode active |
| sw_en_o | output | 1 | Switching allowed |
| gate_o | output | 1 | Burst PWM gate request |
| low_ilim_o | output | 1 | Select the reduced current limit |
| valley_rst_o | output | 1 | One-cycle request to set the valley counter to 1 |

## Verification
The bench breaks the blanking window one cycle short of entry. A design that did not restart the count would then enter burst early. It sets both hysteresis flags at once and holds neither for stretches: a design with the wrong priority, or one that drifts, changes sw_en_o at the wrong edge. It applies trips in the turn-on cycle and in mid-pulse, and runs untripped pulses, which would expose a wrong duty limit or a premature cut. It also applies exit and burst flags in normal mode, where a careless design would issue stray valley resets or gate pulses.

// File: rtl/lite_burst_pkg.sv
package lite_burst_pkg;
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_BURST = 1'b1} mode_e;
endpackage

// File: rtl/lite_burst_entry.sv
module lite_burst_entry #(
  parameter int BLANK_CYC = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cond_i,
  output logic fire_o
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  logic [CW-1:0] cnt_q;

  assign fire_o = arm_i && cond_i && (cnt_q == CW'(BLANK_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!arm_i || !cond_i)    cnt_q <= '0;  // any break restarts the window
    else if (fire_o)               cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lite_burst_hyst.sv
module lite_burst_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic on_i,
  input  logic off_i,
  output logic en_o
);
  logic en_q;
  assign en_o = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (!active_i) en_q <= 1'b0;
    else if (on_i)      en_q <= 1'b1;
    else if (off_i)     en_q <= 1'b0;
  end
endmodule

// File: rtl/lite_burst_pwm.sv
module lite_burst_pwm #(
  parameter int PERIOD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trip_i,
  output logic gate_o
);
  localparam int PW   = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam int HALF = PERIOD_CYC / 2;
  logic [PW-1:0] ph_q;
  logic          gate_q;

  assign gate_o = gate_q && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      gate_q <= 1'b0;
    end else if (!en_i) begin
      ph_q   <= '0;
      gate_q <= 1'b0;
    end else begin
      if (ph_q == '0)                           gate_q <= 1'b1;  // timer turn-on
      else if (trip_i || ph_q == PW'(HALF))     gate_q <= 1'b0;  // first of trip or duty cap
      ph_q <= (ph_q == PW'(PERIOD_CYC - 1)) ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/lite_burst_ctrl.sv
module lite_burst_ctrl
  import lite_burst_pkg::*;
#(
  parameter int BLANK_CYC  = 24,
  parameter int PERIOD_CYC = 8,
  parameter int VT_W       = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fb_low_i,
  input  logic [VT_W-1:0] valley_tgt_i,
  input  logic            fb_on_i,
  input  logic            fb_off_i,
  input  logic            fb_exit_i,
  input  logic            cur_trip_i,
  output logic            burst_o,
  output logic            sw_en_o,
  output logic            gate_o,
  output logic            low_ilim_o,
  output logic            valley_rst_o
);
  localparam logic [VT_W-1:0] VT_MAX = '1;

  mode_e mode_q;
  logic  fire, en, exit_req, vrst_q;

  assign exit_req = (mode_q == MODE_BURST) && fb_exit_i;

  lite_burst_entry #(.BLANK_CYC(BLANK_CYC)) u_entry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (mode_q == MODE_NORMAL),
    .cond_i (fb_low_i && (valley_tgt_i == VT_MAX)),
    .fire_o (fire)
  );

  lite_burst_hyst u_hyst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i ((mode_q == MODE_BURST) && !exit_req),
    .on_i     (fb_on_i),
    .off_i    (fb_off_i),
    .en_o     (en)
  );

  lite_burst_pwm #(.PERIOD_CYC(PERIOD_CYC)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .trip_i (cur_trip_i),
    .gate_o (gate_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      vrst_q <= 1'b0;
    end else begin
      vrst_q <= exit_req;
      if (fire)          mode_q <= MODE_BURST;
      else if (exit_req) mode_q <= MODE_NORMAL;
    end
  end

  assign burst_o      = (mode_q == MODE_BURST);
  assign low_ilim_o   = burst_o;
  assign sw_en_o      = !burst_o || en;
  assign valley_rst_o = vrst_q;
endmodule

// File: rtl/lite_burst_chk.sv
module lite_burst_chk #(
  parameter int PERIOD_CYC = 8,
  parameter int VT_W       = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fb_low_i,
  input logic [VT_W-1:0] valley_tgt_i,
  input logic            fb_on_i,
  input logic            fb_off_i,
  input logic            fb_exit_i,
  input logic            burst_o,
  input logic            sw_en_o,
  input logic            gate_o,
  input logic            low_ilim_o,
  input logic            valley_rst_o
);
  int unsigned hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_run <= 0;
    else if (gate_o) hi_run <= hi_run + 1;
    else             hi_run <= 0;
  end

  AST_ENTRY_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_o) |-> $past(fb_low_i) && ($past(valley_tgt_i) == {VT_W{1'b1}})); // R2
  AST_HYST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o && !fb_exit_i && fb_off_i && !fb_on_i |=> !sw_en_o); // R4
  AST_HYST_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o && !fb_exit_i && fb_on_i |=> sw_en_o && burst_o); // R4
  AST_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run <= PERIOD_CYC / 2); // R5
  AST_NO_GATE_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_o |-> !gate_o); // R5
  AST_EXIT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o && fb_exit_i |=> !burst_o && !low_ilim_o); // R8
  AST_EXIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(burst_o) |-> valley_rst_o); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valley_rst_o |=> !valley_rst_o); // R9
endmodule

bind lite_burst_ctrl lite_burst_chk #(.PERIOD_CYC(PERIOD_CYC), .VT_W(VT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fb_low_i(fb_low_i), .valley_tgt_i(valley_tgt_i),
  .fb_on_i(fb_on_i), .fb_off_i(fb_off_i), .fb_exit_i(fb_exit_i), .burst_o(burst_o),
  .sw_en_o(sw_en_o), .gate_o(gate_o), .low_ilim_o(low_ilim_o), .valley_rst_o(valley_rst_o)
);

// File: tb/lite_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module lite_burst_ctrl_tb_top;
  localparam int BLANK = 24;
  localparam int PER   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fb_low = 0, fb_on = 0, fb_off = 0, fb_exit = 0, trip = 0;
  logic [2:0] vt = 3'd1;
  logic burst, sw_en, gate, low_ilim, vrst;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  lite_burst_ctrl #(.BLANK_CYC(BLANK), .PERIOD_CYC(PER), .VT_W(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fb_low_i(fb_low), .valley_tgt_i(vt),
    .fb_on_i(fb_on), .fb_off_i(fb_off), .fb_exit_i(fb_exit), .cur_trip_i(trip),
    .burst_o(burst), .sw_en_o(sw_en), .gate_o(gate), .low_ilim_o(low_ilim),
    .valley_rst_o(vrst)
  );

  // behavioural reference
  bit m_burst, m_en, m_gate, m_vr;
  int m_cnt, m_ph;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_burst = 0; m_en = 0; m_gate = 0; m_vr = 0; m_cnt = 0; m_ph = 0;
    end else begin
      bit old_en;
      old_en = m_en;
      if (!m_burst) begin
        m_vr = 0; m_en = 0;
        if (fb_low && vt == 3'd7) begin
          if (m_cnt == BLANK - 1) begin m_burst = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end else begin
        m_cnt = 0;
        if (fb_exit) begin m_burst = 0; m_vr = 1; m_en = 0; end
        else begin
          m_vr = 0;
          if (fb_on) m_en = 1; else if (fb_off) m_en = 0;
        end
      end
      if (!old_en) begin m_ph = 0; m_gate = 0; end
      else begin
        if (m_ph == 0) m_gate = 1;
        else if (trip || m_ph == PER / 2) m_gate = 0;
        m_ph = (m_ph == PER - 1) ? 0 : m_ph + 1;
      end
    end
  end

  task automatic chk(string nm, string rq, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", rq, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("burst_o",      cur_req, burst, m_burst);
    chk("sw_en_o",      cur_req, sw_en, !m_burst || m_en);
    chk("gate_o",       cur_req, gate, m_gate && m_en);
    chk("low_ilim_o",   "R7",    low_ilim, m_burst);
    chk("valley_rst_o", "R9",    vrst, m_vr);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      compare_all();
    end
  endtask

  initial begin
    #(5 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #12;
    cur_req = "R1";
    chk("reset burst_o", "R1", burst, 1'b0);
    chk("reset sw_en_o", "R1", sw_en, 1'b1);
    chk("reset gate_o",  "R1", gate, 1'b0);
    chk("reset valley_rst_o", "R1", vrst, 1'b0);
    rst_n = 1'b1;
    cyc(2);

    // R10: burst-only flags in normal mode
    cur_req = "R10";
    fb_exit = 1; fb_on = 1; trip = 1; cyc(4);
    fb_exit = 0; fb_on = 0; fb_off = 1; cyc(2);
    fb_off = 0; trip = 0;

    // R3: window broken one cycle short, by target then by feedback
    cur_req = "R3";
    fb_low = 1; vt = 3'd7; cyc(BLANK - 1);
    vt = 3'd6; cyc(1); vt = 3'd7;
    cyc(BLANK - 1);
    fb_low = 0; cyc(1); fb_low = 1;
    chk("no early entry", "R3", burst, 1'b0);

    // R2: full window enters burst
    cur_req = "R2";
    cyc(BLANK);
    chk("entered burst", "R2", burst, 1'b1);
    chk("sw off at entry", "R4", sw_en, 1'b0);
    fb_low = 0;

    // R4: hysteresis
    cur_req = "R4";
    cyc(3);
    fb_on = 1; fb_off = 1; cyc(1);
    chk("on wins", "R4", sw_en, 1'b1);
    fb_on = 0; fb_off = 0;

    // R5: untripped pulses
    cur_req = "R5";
    cyc(3 * PER);

    // R6: trips at various phases
    cur_req = "R6";
    for (int k = 0; k < 3 * PER; k++) begin
      trip = (k % 3 == 0);
      cyc(1);
    end
    trip = 0;
    cyc(PER);

    cur_req = "R4";
    fb_off = 1; cyc(1); fb_off = 0;
    chk("sw off", "R4", sw_en, 1'b0);
    cyc(5);
    fb_on = 1; cyc(1); fb_on = 0;
    cyc(PER + 3);

    // R8: exit mid pulse
    cur_req = "R8";
    fb_exit = 1; cyc(1); fb_exit = 0;
    chk("exit burst", "R8", burst, 1'b0);
    chk("exit gate", "R8", gate, 1'b0);
    chk("exit pulse", "R9", vrst, 1'b1);
    cyc(1);
    chk("pulse one cycle", "R9", vrst, 1'b0);

    cur_req = "R10";
    fb_exit = 1; cyc(3); fb_exit = 0;
    cyc(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule